// File: doc/BRIEF.md
# Pipelined Synchronous Static RAM with Byte Writes

This block models a single-port synchronous static RAM whose word is split into byte lanes, with a default of four 8-bit lanes forming a 32-bit word. On each rising clock edge it samples the address, the write data and all access controls: chip select, sleep, write enable, global write and the per-byte lane selects. On the next rising edge it carries out the access. A write updates the memory array. A read loads the addressed word into an output register, so read data appears on the output one edge after the request was registered.

The access kind and the byte mask are decoded before the input register. A global write stores every lane no matter what the other write inputs are. A plain write stores only the lanes whose selects are high. A request taken while the chip is deselected or asleep is dropped at the input, so deselect takes effect after a single cycle. The output enable is not clocked. It forces the data bus to zero and the valid flag low without touching the held word. A read issued in the cycle after a write to the same address returns the new data, because the write commits on the edge that registers the read.

Top module: `burst_sram_pipe`

## Requirements
- R1: A read registered at edge N (cs=1, zz=0, we=0, gw=0) drives the stored word on dout with dout_vld=1 after edge N+1, provided oe_n is low.
- R2: With we=1 and gw=0, lane k (bits 8k+7..8k, lane 0 being the least significant byte) is written from din only when be[k]=1. Unselected lanes keep their contents.
- R3: With gw=1, all four lanes are written, whatever we and be are.
- R4: With we=1 and be=4'b1111, the whole word is written.
- R5: A write request, including we=1 with be=0, produces no read data: dout_vld is low after edge N+1 and dout keeps the previously read word. A request with we=1 and be=0 changes no memory contents.
- R6: A request sampled with cs=0 has no effect on memory, and dout_vld is low after the next edge (single-cycle deselect). dout keeps its value.
- R7: While zz=1 at a sampling edge, both reads and writes are ignored, dout_vld is low after the next edge and dout holds its value.
- R8: oe_n=1 forces dout to all zeros and dout_vld low combinationally. Returning oe_n to 0 restores the held word.
- R9: A read registered on the edge right after a write to the same address returns the newly written data.
- R10: After reset, dout is zero, dout_vld is low and every memory word reads as zero (INIT_ZERO=1).
- R11: Reads issued on consecutive cycles return one word per cycle, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, sampled |
| zz | input | 1 | Sleep request, sampled; blocks all accesses |
| we | input | 1 | Write enable for the selected lanes, sampled |
| gw | input | 1 | Global write of all lanes, sampled |
| be | input | NUM_BYTES (4) | Per-lane write selects, sampled |
| addr | input | ADDR_W (4) | Word address, sampled |
| din | input | NUM_BYTES*BYTE_W (32) | Write data, sampled |
| oe_n | input | 1 | Active-low output enable, combinational |
| dout | output | NUM_BYTES*BYTE_W (32) | Registered read data, zero while oe_n is high |
| dout_vld | output | 1 | High when dout carries data from a read |

## Verification
The bench builds the block with its defaults: a 4-bit address (16 words), four 8-bit lanes and INIT_ZERO=1. At this depth a reference array in the bench can mirror every word. The zero-initialised array makes a read before any write a defined check of reset contents. With four lanes, the bench can apply alternating and partial lane masks and check a merged word, which a single-lane build could not exercise.

// File: rtl/psram_pkg.sv
package psram_pkg;

   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_kind_e;

endpackage

// File: rtl/psram_wr_decode.sv
module psram_wr_decode
   import psram_pkg::*;
#(
   parameter int NUM_BYTES = 4
) (
   input  logic                 cs,
   input  logic                 zz,
   input  logic                 we,
   input  logic                 gw,
   input  logic [NUM_BYTES-1:0] be,
   output acc_kind_e            kind,
   output logic [NUM_BYTES-1:0] mask
);

   always_comb begin
      kind = ACC_IDLE;
      mask = '0;
      if (cs && !zz) begin
         if (gw) begin
            kind = ACC_WRITE;
            mask = '1;
         end else if (we) begin
            kind = ACC_WRITE;
            mask = be;
         end else begin
            kind = ACC_READ;
         end
      end
   end

endmodule

// File: rtl/psram_in_stage.sv
module psram_in_stage
   import psram_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int NUM_BYTES = 4,
   parameter int BYTE_W    = 8,
   localparam int DATA_W   = NUM_BYTES * BYTE_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  acc_kind_e            kind_d,
   input  logic [NUM_BYTES-1:0] mask_d,
   input  logic [ADDR_W-1:0]    addr_d,
   input  logic [DATA_W-1:0]    data_d,
   output acc_kind_e            kind_q,
   output logic [NUM_BYTES-1:0] mask_q,
   output logic [ADDR_W-1:0]    addr_q,
   output logic [DATA_W-1:0]    data_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q <= ACC_IDLE;
         mask_q <= '0;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         kind_q <= kind_d;
         mask_q <= mask_d;
         addr_q <= addr_d;
         data_q <= data_d;
      end
   end

endmodule

// File: rtl/psram_array.sv
module psram_array #(
   parameter int ADDR_W    = 4,
   parameter int NUM_BYTES = 4,
   parameter int BYTE_W    = 8,
   parameter bit INIT_ZERO = 1'b1,
   localparam int DEPTH    = 1 << ADDR_W,
   localparam int DATA_W   = NUM_BYTES * BYTE_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [NUM_BYTES-1:0] wr_mask,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    rdata
);

   for (genvar ln = 0; ln < NUM_BYTES; ln++) begin : g_lane
      logic [BYTE_W-1:0] mem [DEPTH];
      logic              lane_we;

      assign lane_we = wr_en && wr_mask[ln];
      assign rdata[ln*BYTE_W +: BYTE_W] = mem[addr];

      if (INIT_ZERO) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int w = 0; w < DEPTH; w++) begin
                  mem[w] <= '0;
               end
            end else if (lane_we) begin
               mem[addr] <= wdata[ln*BYTE_W +: BYTE_W];
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (lane_we) begin
               mem[addr] <= wdata[ln*BYTE_W +: BYTE_W];
            end
         end
      end
   end

endmodule

// File: rtl/psram_out_stage.sv
module psram_out_stage #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_fire,
   input  logic [DATA_W-1:0] rdata,
   input  logic              oe_n,
   output logic [DATA_W-1:0] dout,
   output logic              dout_vld
);

   logic [DATA_W-1:0] hold_q;
   logic              vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         vld_q  <= 1'b0;
      end else begin
         vld_q <= rd_fire;
         if (rd_fire) begin
            hold_q <= rdata;
         end
      end
   end

   assign dout     = oe_n ? '0 : hold_q;
   assign dout_vld = vld_q && !oe_n;

endmodule

// File: rtl/burst_sram_pipe.sv
module burst_sram_pipe
   import psram_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int NUM_BYTES = 4,
   parameter int BYTE_W    = 8,
   parameter bit INIT_ZERO = 1'b1,
   localparam int DATA_W   = NUM_BYTES * BYTE_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs,
   input  logic                 zz,
   input  logic                 we,
   input  logic                 gw,
   input  logic [NUM_BYTES-1:0] be,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    din,
   input  logic                 oe_n,
   output logic [DATA_W-1:0]    dout,
   output logic                 dout_vld
);

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("burst_sram_pipe: ADDR_W must lie in 1..12");
   end
   if (NUM_BYTES < 1) begin : g_bad_lanes
      $error("burst_sram_pipe: NUM_BYTES must be at least 1");
   end
   if (BYTE_W < 1) begin : g_bad_bw
      $error("burst_sram_pipe: BYTE_W must be at least 1");
   end

   acc_kind_e            kind_d, kind_q;
   logic [NUM_BYTES-1:0] mask_d, mask_q;
   logic [ADDR_W-1:0]    addr_q;
   logic [DATA_W-1:0]    data_q;
   logic [DATA_W-1:0]    arr_rdata;

   psram_wr_decode #(
      .NUM_BYTES (NUM_BYTES)
   ) u_dec (
      .cs   (cs),
      .zz   (zz),
      .we   (we),
      .gw   (gw),
      .be   (be),
      .kind (kind_d),
      .mask (mask_d)
   );

   psram_in_stage #(
      .ADDR_W    (ADDR_W),
      .NUM_BYTES (NUM_BYTES),
      .BYTE_W    (BYTE_W)
   ) u_in (
      .clk    (clk),
      .rst_n  (rst_n),
      .kind_d (kind_d),
      .mask_d (mask_d),
      .addr_d (addr),
      .data_d (din),
      .kind_q (kind_q),
      .mask_q (mask_q),
      .addr_q (addr_q),
      .data_q (data_q)
   );

   psram_array #(
      .ADDR_W    (ADDR_W),
      .NUM_BYTES (NUM_BYTES),
      .BYTE_W    (BYTE_W),
      .INIT_ZERO (INIT_ZERO)
   ) u_arr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (kind_q == ACC_WRITE),
      .wr_mask (mask_q),
      .addr    (addr_q),
      .wdata   (data_q),
      .rdata   (arr_rdata)
   );

   psram_out_stage #(
      .DATA_W (DATA_W)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_fire  (kind_q == ACC_READ),
      .rdata    (arr_rdata),
      .oe_n     (oe_n),
      .dout     (dout),
      .dout_vld (dout_vld)
   );

endmodule

// File: rtl/burst_sram_pipe_chk.sv
module burst_sram_pipe_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs,
   input logic              zz,
   input logic              we,
   input logic              gw,
   input logic              oe_n,
   input logic [DATA_W-1:0] dout,
   input logic              dout_vld
);

   // R8
   oe_gates_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> (dout == '0 && !dout_vld));

   // R1
   read_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && !zz && !we && !gw) |-> ##2 (oe_n || dout_vld));

   // R5
   write_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && (we || gw)) |-> ##2 !dout_vld);

   // R6
   deselect_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |-> ##2 !dout_vld);

   // R7
   sleep_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      zz |-> ##2 !dout_vld);

   // R5
   held_word_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dout_vld && !oe_n && $past(!oe_n)) |-> $stable(dout));

endmodule

bind burst_sram_pipe burst_sram_pipe_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs       (cs),
   .zz       (zz),
   .we       (we),
   .gw       (gw),
   .oe_n     (oe_n),
   .dout     (dout),
   .dout_vld (dout_vld)
);

// File: tb/sim_burst_sram_pipe.sv
module sim_burst_sram_pipe;

   localparam int AW = 4;
   localparam int NB = 4;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs = 1'b0, zz = 1'b0, we = 1'b0, gw = 1'b0, oe_n = 1'b0;
   logic [NB-1:0] be = '0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          dout_vld;

   int checks = 0;
   int errors = 0;
   logic [DW-1:0] ref_mem [1<<AW];
   logic [DW-1:0] last_out = '0;

   always #10 clk = ~clk;

   burst_sram_pipe u0 (
      .clk(clk), .rst_n(rst_n), .cs(cs), .zz(zz), .we(we), .gw(gw),
      .be(be), .addr(addr), .din(din), .oe_n(oe_n),
      .dout(dout), .dout_vld(dout_vld)
   );

   task automatic check(input string req, input logic [DW-1:0] got_d,
                        input logic got_v, input logic [DW-1:0] exp_d,
                        input logic exp_v);
      checks++;
      if (got_d !== exp_d || got_v !== exp_v) begin
         errors++;
         $display("FAIL %s dout=%h vld=%b expected dout=%h vld=%b",
                  req, got_d, got_v, exp_d, exp_v);
      end
   endtask

   task automatic drive(input logic c, input logic z, input logic w, input logic g,
                        input logic [NB-1:0] b, input logic [AW-1:0] a,
                        input logic [DW-1:0] d);
      cs = c; zz = z; we = w; gw = g; be = b; addr = a; din = d;
   endtask

   task automatic model(input logic c, input logic z, input logic w, input logic g,
                        input logic [NB-1:0] b, input logic [AW-1:0] a,
                        input logic [DW-1:0] d);
      if (c && !z) begin
         if (g) ref_mem[a] = d;
         else if (w)
            for (int k = 0; k < NB; k++)
               if (b[k]) ref_mem[a][k*8 +: 8] = d[k*8 +: 8];
      end
   endtask

   // one request, then idle; returns at the negedge after the result edge
   task automatic op(input logic c, input logic z, input logic w, input logic g,
                     input logic [NB-1:0] b, input logic [AW-1:0] a,
                     input logic [DW-1:0] d);
      @(negedge clk) drive(c, z, w, g, b, a, d);
      model(c, z, w, g, b, a, d);
      @(negedge clk) drive(0, 0, 0, 0, '0, '0, '0);
      @(negedge clk);
   endtask

   task automatic rd_check(input logic [AW-1:0] a, input string req);
      op(1, 0, 0, 0, '0, a, '0);
      check(req, dout, dout_vld, ref_mem[a], 1'b1);
      last_out = ref_mem[a];
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R10 reset outputs", dout, dout_vld, '0, 1'b0);
      rd_check(4'd3, "R10 array cleared");
   endtask

   task automatic t_full_word;
      op(1, 0, 1, 0, 4'b1111, 4'd1, 32'hDEAD_BEEF);
      rd_check(4'd1, "R4 full word via lane selects");
      rd_check(4'd1, "R1 read latency");
   endtask

   task automatic t_byte_lanes;
      op(1, 0, 0, 1, 4'b0000, 4'd2, 32'hA5A5_A5A5);
      op(1, 0, 1, 0, 4'b0101, 4'd2, 32'h1122_3344);
      rd_check(4'd2, "R2 lanes 0 and 2");
      check("R2 merged value", last_out, 1'b1, 32'hA522_A544, 1'b1);
      op(1, 0, 1, 0, 4'b1000, 4'd2, 32'h7700_0000);
      rd_check(4'd2, "R2 lane 3 only");
   endtask

   task automatic t_global;
      op(1, 0, 0, 1, 4'b0000, 4'd4, 32'h0102_0304);
      rd_check(4'd4, "R3 global write, we low");
      op(1, 0, 1, 1, 4'b0011, 4'd4, 32'hCAFE_F00D);
      rd_check(4'd4, "R3 global write overrides lanes");
   endtask

   task automatic t_no_lanes;
      rd_check(4'd4, "R5 setup read");
      op(1, 0, 1, 0, 4'b0000, 4'd4, 32'h5555_5555);
      check("R5 empty-mask write holds dout", dout, dout_vld, last_out, 1'b0);
      rd_check(4'd4, "R5 empty-mask write changed nothing");
   endtask

   task automatic t_deselect;
      op(0, 0, 0, 1, 4'b1111, 4'd1, 32'h1234_5678);
      check("R6 deselect valid low", dout, dout_vld, last_out, 1'b0);
      rd_check(4'd1, "R6 deselected write ignored");
   endtask

   task automatic t_sleep;
      op(1, 1, 0, 1, 4'b1111, 4'd1, 32'h9999_0000);
      check("R7 sleep write, valid low", dout, dout_vld, last_out, 1'b0);
      op(1, 1, 0, 0, 4'b0000, 4'd2, '0);
      check("R7 sleep read, valid low", dout, dout_vld, last_out, 1'b0);
      rd_check(4'd1, "R7 sleep write ignored");
   endtask

   task automatic t_oe;
      rd_check(4'd2, "R8 setup read");
      @(negedge clk);
      oe_n = 1'b1;
      #1 check("R8 oe high gates bus", dout, dout_vld, '0, 1'b0);
      oe_n = 1'b0;
      #1 check("R8 oe low restores word", dout, 1'b1, last_out, 1'b1);
   endtask

   task automatic t_raw;
      @(negedge clk) drive(1, 0, 1, 0, 4'b1111, 4'd9, 32'hFEED_0009);
      model(1, 0, 1, 0, 4'b1111, 4'd9, 32'hFEED_0009);
      @(negedge clk) drive(1, 0, 0, 0, '0, 4'd9, '0);
      @(negedge clk) drive(0, 0, 0, 0, '0, '0, '0);
      @(negedge clk);
      check("R9 read right after write", dout, dout_vld, 32'hFEED_0009, 1'b1);
      last_out = dout;
   endtask

   task automatic t_stream;
      @(negedge clk) drive(1, 0, 0, 0, '0, 4'd1, '0);
      @(negedge clk) drive(1, 0, 0, 0, '0, 4'd2, '0);
      @(negedge clk) drive(1, 0, 0, 0, '0, 4'd9, '0);
      check("R11 stream word 0", dout, dout_vld, ref_mem[1], 1'b1);
      @(negedge clk) drive(0, 0, 0, 0, '0, '0, '0);
      check("R11 stream word 1", dout, dout_vld, ref_mem[2], 1'b1);
      @(negedge clk);
      check("R11 stream word 2", dout, dout_vld, ref_mem[9], 1'b1);
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_full_word();
      t_byte_lanes();
      t_global();
      t_no_lanes();
      t_deselect();
      t_sleep();
      t_oe();
      t_raw();
      t_stream();
      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule